// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one channel of general-purpose I/O with up to sixteen pins, reached through a simple 32-bit word-addressed register port. Software sets pin direction and output data, reads the synchronized pin levels and arms interrupt detection on any pin. Each pin has its own trigger mode: falling edge, rising edge, both edges, level low or level high. It also has its own enable, pending-status, mask and clear controls. One interrupt line is raised when any pending pin is not masked.

Writes take effect at the clock edge on which `wr_en` is sampled high. Reads are combinational from `rd_addr`. The mask can only be changed through a set port and a clear port, so two agents that own different pins never need a read-modify-write. A soft-reset word holds every register at its default for as long as its bit 0 stays at 1.

Register words, by index: 0 enable, 1 status, 2 display (status with masked pins removed), 3 clear, 4 mask set (reads back the mask), 5 mask clear (reads zero), 6 output data, 7 input level, 8 direction, 9 mode low, 10 mode high, 11 reserved (reads zero), 12 soft reset.

Top module: `gpio_irq_bank`

## Requirements
- R1: After `rst_n` is released, every register word reads zero (the input word reads the synchronized pin level), and `irq`, `pin_oe` and `pin_out` are all zero.
- R2: `pin_oe` follows the direction word (word 8, 1 = output) and `pin_out` follows the output word (word 6). Bits at or above NPINS are dropped on write and read as zero.
- R3: Word 7 returns each pin's level through a two-flop synchronizer. A pin change made between clock edges is visible after the second following edge and not after the first.
- R4: Each pin has a 3-bit mode field in a 4-bit slot. Pins 0–7 use word 9 at bit pin×4 and pins 8–15 use word 10 at bit (pin−8)×4. Slot bit 3, and the slots of pins at or above NPINS, read as zero.
- R5: Mode 0 detects a falling edge, mode 1 a rising edge and mode 4 either edge. An edge made between clock edges sets the pin's status bit (word 1) on the third following clock edge.
- R6: Mode 2 (level low) and mode 3 (level high) set the status bit on every clock while the level is present. A clear made while the level persists therefore leaves the bit set. Once the level is gone, the bit stays set until it is cleared.
- R7: A pin whose enable bit (word 0) is 0 never sets its status bit.
- R8: Writing 1 to a bit of word 3 clears that status bit. Writing 0 leaves it unchanged.
- R9: Writing 1 to a bit of word 4 masks that pin and writing 1 to word 5 unmasks it. Zero bits leave the mask unchanged. Word 4 reads the mask and word 5 reads zero.
- R10: Word 2 reads status AND NOT mask. `irq` is the OR of those bits, registered one cycle later.
- R11: While bit 0 of word 12 is 1, all other registers are held at their defaults and writes to them are lost. Word 12 reads back the bit, and normal writes work again after it is written to 0.
- R12: Mode codes 5, 6 and 7 never set a status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word index of the combinational read |
| rd_data | output | 32 | Read data |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Channel interrupt |

## Verification
A pin change reaches word 7 after two edges and the status word after three, and `irq` follows the display word one edge later. The bench changes pins on falling clock edges and counts rising edges before each sample. It also samples once one edge early, to show that a result is not yet present. A register write takes effect at the edge that captures it, so readback is sampled at the falling edge just after. For soft reset, one extra edge is allowed for the held-default state. The trigger sweep covers all eight mode codes on all pins, with expected status computed from the mode number and the direction of the edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;
  localparam int MODE_W = 3;
  localparam int SLOT_W = 4;
  localparam int SLOTS_PER_WORD = WORD_W / SLOT_W;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE   = 4'd0,
    A_STATUS   = 4'd1,
    A_DISPLAY  = 4'd2,
    A_CLEAR    = 4'd3,
    A_MASK_SET = 4'd4,
    A_MASK_CLR = 4'd5,
    A_OUT      = 4'd6,
    A_IN       = 4'd7,
    A_DIR      = 4'd8,
    A_MODE_LO  = 4'd9,
    A_MODE_HI  = 4'd10,
    A_RSVD     = 4'd11,
    A_SRST     = 4'd12
  } reg_addr_e;

  typedef enum logic [MODE_W-1:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  // Event decision for one pin from its mode and two successive samples.
  function automatic logic trig_hit(input logic [MODE_W-1:0] mode,
                                    input logic cur, input logic prev);
    case (mode)
      TRIG_FALL: trig_hit = prev & ~cur;
      TRIG_RISE: trig_hit = ~prev & cur;
      TRIG_LOW:  trig_hit = ~cur;
      TRIG_HIGH: trig_hit = cur;
      TRIG_BOTH: trig_hit = prev ^ cur;
      default:   trig_hit = 1'b0;
    endcase
  endfunction

  // Bit position of a pin's mode slot inside its mode word.
  function automatic int slot_lsb(input int pin);
    return (pin % SLOTS_PER_WORD) * SLOT_W;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_trig_bank.sv
module gpio_trig_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        level,
  input  logic [NPINS*MODE_W-1:0] mode_flat,
  output logic [NPINS-1:0]        hit
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign hit[p] = trig_hit(mode_flat[p*MODE_W +: MODE_W], level[p], prev_q[p]);

    // R12
    bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_flat[p*MODE_W +: MODE_W] > 3'd4) |-> !hit[p]);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int MFLAT_W = NPINS * MODE_W;

  logic [NPINS-1:0] en_q, status_q, mask_q, out_q, dir_q;
  logic [NPINS-1:0] lvl_sync, hit_vec, evt_vec, display;
  logic [NPINS-1:0] wpins, clr_req, mset_req, mclr_req;
  logic [MFLAT_W-1:0] mode_flat;
  logic srst_q, irq_q;
  logic [WORD_W-1:0] mode_lo_word, mode_hi_word;

  function automatic logic [WORD_W-1:0] widen(input logic [NPINS-1:0] v);
    widen = '0;
    widen[NPINS-1:0] = v;
  endfunction

  function automatic logic wr_to(input reg_addr_e a);
    return wr_en && (wr_addr == a);
  endfunction

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
  );

  gpio_trig_bank #(.NPINS(NPINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .level(lvl_sync), .mode_flat(mode_flat), .hit(hit_vec)
  );

  assign wpins    = wr_data[NPINS-1:0];
  assign clr_req  = wr_to(A_CLEAR)    ? wpins : '0;
  assign mset_req = wr_to(A_MASK_SET) ? wpins : '0;
  assign mclr_req = wr_to(A_MASK_CLR) ? wpins : '0;
  assign evt_vec  = hit_vec & en_q;
  assign display  = status_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else if (wr_to(A_SRST)) srst_q <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; status_q <= '0; mask_q <= '0;
      out_q <= '0; dir_q <= '0; irq_q <= 1'b0;
    end else if (srst_q) begin
      en_q <= '0; status_q <= '0; mask_q <= '0;
      out_q <= '0; dir_q <= '0; irq_q <= 1'b0;
    end else begin
      if (wr_to(A_ENABLE)) en_q  <= wpins;
      if (wr_to(A_OUT))    out_q <= wpins;
      if (wr_to(A_DIR))    dir_q <= wpins;
      status_q <= (status_q & ~clr_req) | evt_vec;
      mask_q   <= (mask_q | mset_req) & ~mclr_req;
      irq_q    <= |display;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_mode
    localparam reg_addr_e MADDR = (p < SLOTS_PER_WORD) ? A_MODE_LO : A_MODE_HI;
    localparam int        LSB   = slot_lsb(p);
    logic [MODE_W-1:0] mode_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mode_r <= '0;
      else if (srst_q)                        mode_r <= '0;
      else if (wr_en && (wr_addr == MADDR))   mode_r <= wr_data[LSB +: MODE_W];
    end
    assign mode_flat[p*MODE_W +: MODE_W] = mode_r;
  end

  always_comb begin
    mode_lo_word = '0;
    mode_hi_word = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (p < SLOTS_PER_WORD) mode_lo_word[slot_lsb(p) +: MODE_W] = mode_flat[p*MODE_W +: MODE_W];
      else                    mode_hi_word[slot_lsb(p) +: MODE_W] = mode_flat[p*MODE_W +: MODE_W];
    end
  end

  always_comb begin
    case (rd_addr)
      A_ENABLE:   rd_data = widen(en_q);
      A_STATUS:   rd_data = widen(status_q);
      A_DISPLAY:  rd_data = widen(display);
      A_MASK_SET: rd_data = widen(mask_q);
      A_OUT:      rd_data = widen(out_q);
      A_IN:       rd_data = widen(lvl_sync);
      A_DIR:      rd_data = widen(dir_q);
      A_MODE_LO:  rd_data = mode_lo_word;
      A_MODE_HI:  rd_data = mode_hi_word;
      A_SRST:     rd_data = {{(WORD_W-1){1'b0}}, srst_q};
      default:    rd_data = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = irq_q;

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));

  // R8
  clear_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_to(A_CLEAR) && !srst_q) |=> ((status_q & $past(wpins & ~evt_vec)) == '0));

  // R9
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_to(A_MASK_SET) && !srst_q) |=> ((mask_q & $past(wpins)) == $past(wpins)));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_to(A_MASK_SET) && !wr_to(A_MASK_CLR) && !srst_q) |=> $stable(mask_q));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(display) != '0));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (en_q == '0 && status_q == '0 && mask_q == '0 &&
                dir_q == '0 && out_q == '0 && !irq));
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int N = 12;
  localparam logic [31:0] ALL = 32'h0000_0FFF;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NPINS(N)) u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a; #1; chk(req, rd_data, exp);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Mode word with code m in every 4-bit slot.
  function automatic logic [31:0] mword(input int m);
    return 32'(m) * 32'h1111_1111;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat, rise_exp, fall_exp;
    edges(3); rst_n = 1'b1; edges(2);

    // R1 reset state
    for (int a = 0; a <= 12; a++) rd_chk("R1", 4'(a), 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 oe", 32'(pin_oe), 32'h0);
    chk("R1 out", 32'(pin_out), 32'h0);

    // R2 direction and output data
    wr(8, 32'hFFFF_FFFF); rd_chk("R2 dir", 8, ALL); chk("R2 oe", 32'(pin_oe), ALL);
    wr(6, 32'h0000_0A5A); rd_chk("R2 out", 6, 32'hA5A); chk("R2 pin_out", 32'(pin_out), 32'hA5A);
    wr(6, 32'hFFFF_FFFF); rd_chk("R2 out wide", 6, ALL);
    wr(8, 32'h0000_0030); chk("R2 oe part", 32'(pin_oe), 32'h30);
    wr(8, 0); wr(6, 0);

    // R3 input synchronizer latency
    pin_in = 12'h5A3; edges(1); rd_chk("R3 early", 7, 32'h0);
    edges(1); rd_chk("R3", 7, 32'h5A3);

    // R4 mode slot placement
    wr(9, 32'hFFFF_FFFF); rd_chk("R4 lo", 9, 32'h7777_7777);
    wr(10, 32'hFFFF_FFFF); rd_chk("R4 hi", 10, 32'h0000_7777);
    wr(9, 32'h1234_5678); rd_chk("R4 lo pattern", 9, 32'h1234_5670);
    rd_chk("R4 reserved", 11, 32'h0);

    // R5 / R12 edge sweep over every mode code
    pin_in = '0; wr(0, ALL);
    for (int m = 0; m < 8; m++) begin
      if (m == 2 || m == 3) continue;
      pat = N'(12'h5A3 << m) | 12'h001;
      rise_exp = (m == 1 || m == 4) ? pat : '0;
      fall_exp = (m == 0 || m == 4) ? pat : '0;
      wr(9, mword(m)); wr(10, mword(m));
      edges(3); wr(3, ALL);
      pin_in = pat; edges(2);
      rd_chk((m > 4) ? "R12 early" : "R5 early", 1, 32'h0);
      edges(1);
      rd_chk((m > 4) ? "R12 rise" : "R5 rise", 1, 32'(rise_exp));
      wr(3, ALL);
      pin_in = '0; edges(3);
      rd_chk((m > 4) ? "R12 fall" : "R5 fall", 1, 32'(fall_exp));
      wr(3, ALL);
    end

    // R6 level modes
    wr(9, mword(3)); wr(10, mword(3)); wr(3, ALL);
    rd_chk("R6 idle", 1, 32'h0);
    pin_in = 12'h0F0; edges(3); rd_chk("R6 high", 1, 32'h0F0);
    wr(3, ALL); rd_chk("R6 reassert", 1, 32'h0F0);
    pin_in = '0; edges(3); rd_chk("R6 sticky", 1, 32'h0F0);
    wr(3, ALL); rd_chk("R6 cleared", 1, 32'h0);
    wr(9, mword(2)); wr(10, mword(2)); edges(1);
    rd_chk("R6 low", 1, ALL);
    pin_in = 12'h0F0; edges(3); wr(3, ALL);
    rd_chk("R6 low part", 1, 32'hF0F);

    // R7 enable gating
    wr(9, mword(3)); wr(10, mword(3));
    wr(0, 0); wr(3, ALL); pin_in = 12'hFFF; edges(4);
    rd_chk("R7 disabled", 1, 32'h0);
    wr(0, 32'h00F); edges(2); rd_chk("R7 partial", 1, 32'h00F);

    // R8 write-1-to-clear
    wr(9, mword(1)); wr(10, mword(1)); wr(0, ALL);
    pin_in = '0; edges(3); wr(3, ALL); rd_chk("R8 clear all", 1, 32'h0);
    pin_in = 12'hFFF; edges(3); rd_chk("R8 set", 1, ALL);
    wr(3, 0); rd_chk("R8 zero write", 1, ALL);
    wr(3, 32'h0F0); rd_chk("R8 partial", 1, 32'hF0F);

    // R9 / R10 mask, display and irq latency
    chk("R10 irq pending", {31'b0, irq}, 32'h1);
    wr(4, 32'h00F); rd_chk("R9 set", 4, 32'h00F); rd_chk("R10 display", 2, 32'hF00);
    wr(4, 0); rd_chk("R9 zero set", 4, 32'h00F);
    wr(5, 32'h003); rd_chk("R9 clr", 4, 32'h00C); rd_chk("R9 clr word", 5, 32'h0);
    rd_chk("R10 display2", 2, 32'hF03);
    wr(5, 0); rd_chk("R9 zero clr", 4, 32'h00C);
    wr(4, ALL); rd_chk("R10 all masked", 2, 32'h0);
    chk("R10 irq lag", {31'b0, irq}, 32'h1);
    edges(1); chk("R10 irq low", {31'b0, irq}, 32'h0);
    wr(5, 32'hF00); rd_chk("R10 unmask", 2, 32'hF00);
    chk("R10 irq still low", {31'b0, irq}, 32'h0);
    edges(1); chk("R10 irq high", {31'b0, irq}, 32'h1);

    // R11 soft reset
    wr(8, 32'h03C); wr(6, 32'h0C3); pin_in = '0;
    wr(12, 1); edges(1);
    rd_chk("R11 flag", 12, 32'h1);
    for (int a = 0; a <= 11; a++) rd_chk("R11 default", 4'(a), 32'h0);
    chk("R11 irq", {31'b0, irq}, 32'h0);
    chk("R11 oe", 32'(pin_oe), 32'h0);
    wr(0, ALL); rd_chk("R11 write lost", 0, 32'h0);
    wr(12, 0); rd_chk("R11 flag off", 12, 32'h0);
    wr(0, 32'h123); rd_chk("R11 resumed", 0, 32'h123);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule